// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block builds and sends the command phase of a byte-oriented SPI register and DMA protocol from the host side. A single `start_i` pulse loads an opcode, an address, a transfer length or data word, a CRC enable and a clockless flag. The encoder then sends the command bytes, most significant byte first, on a byte stream with a valid/ready handshake. When CRC is enabled it adds a CRC7 byte after the command bytes.

After the command bytes it sends filler bytes of 0x00 while it reads back the response. Each response byte is taken from `rx_data_i` in the same handshake as the filler byte going out, which matches the full-duplex nature of an SPI shifter. The response is an echo of the opcode and a status byte. Three special commands have one extra byte ahead of the echo. At the end the encoder gives a one-cycle `done_o` pulse and a 2-bit result code. The SPI shifter, the data phases and the meaning of the registers belong to other blocks.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, `tx_valid_o`, `busy_o` and `done_o` are all low.
- R2: The opcode is always the first byte. Its layout decides the bytes that follow:
  - 0xCA (single read): a 3-byte address.
  - 0xC1 and 0xC2 (DMA write and read): a 3-byte address and then `len_i[15:0]`.
  - 0xC7 and 0xC8 (extended DMA write and read): a 3-byte address and then `len_i[23:0]`.
  - All multi-byte fields are sent big-endian.
- R3: The internal commands are 0xC3 (write) and 0xC4 (read). Their address is 2 bytes: `addr_i[15:8]` with bit 7 forced to 1 when `clockless_i` is set, and then `addr_i[7:0]`. Internal read sends one more byte of 0x00 after the address.
- R4: Single write (0xC9) and internal write (0xC3) send `data_i` big-endian after the address.
- R5: Reset (0xCF) sends address bytes 0xFF 0xFF 0xFF. Terminate (0xC5) and repeat (0xC6) send three 0x00 bytes. Any other opcode is framed like single read.
- R6: When `crc_en_i` is set, the encoder adds one byte after the command bytes. This byte is {crc[6:0], 1'b0}. The CRC uses the polynomial x^7+x^3+1, starts with all ones, and covers every command byte, bit 7 first.
- R7: In the response phase the encoder sends 0x00 bytes. There are 2 of them, or 3 for 0xC5, 0xC6 and 0xCF. For those three commands the first response byte is discarded. The echo is the next byte and the status is the byte after it.
- R8: `done_o` goes high for exactly one cycle, in the cycle after the last response handshake. `result_o` then gives 0 for ok, 1 when the echo does not equal the opcode, and 2 when the status is nonzero. A bad echo takes priority over a bad status.
- R9: With `clockless_i` set, opcodes 0xC3, 0xC4, 0xC9 and 0xCA always report 0. The DMA and special commands are still checked.
- R10: A byte is sent only when `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_data_o` holds its value.
- R11: A `start_i` that arrives while `busy_o` is high is ignored. The frame already in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command; only taken while idle |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| len_i | input | 24 | DMA transfer length |
| data_i | input | 32 | Write data word |
| crc_en_i | input | 1 | Add a CRC7 byte |
| clockless_i | input | 1 | Clockless access; sets the address flag and bypasses the response check |
| tx_valid_o | output | 1 | Byte available on `tx_data_o` |
| tx_data_o | output | 8 | Outgoing byte |
| tx_ready_i | input | 1 | Shifter accepts the byte |
| rx_data_i | input | 8 | Byte shifted in during the current handshake |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 echo mismatch, 2 bad status |

## Verification
The bench runs every frame layout, with and without CRC, under random stalls on `tx_ready_i`. A design that advances a byte on valid alone, or lets the data change during a stall, fails the byte-by-byte compare at once.

The special commands check the skip byte. A design that reads the echo one byte too early reports a mismatch on a good response, or gives `done_o` one byte early.

Further cases cover:
- Both response faults at the same time, which tests the priority of the echo error.
- The clockless bypass on a DMA opcode, where it must not apply.
- Clockless internal accesses, where bit 7 of the address must be set.
- A `start_i` pulse in the middle of a frame, which must not corrupt the bytes still to be sent.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 24;
  localparam int LEN_W      = 24;
  localparam int WORD_W     = 32;
  localparam int CRC_W      = 7;
  localparam int MAX_BYTES  = 8;
  localparam int IDX_W      = $clog2(MAX_BYTES);
  localparam int CNT_W      = IDX_W + 1;

  localparam logic [7:0] OP_DMA_WR   = 8'hC1;
  localparam logic [7:0] OP_DMA_RD   = 8'hC2;
  localparam logic [7:0] OP_INT_WR   = 8'hC3;
  localparam logic [7:0] OP_INT_RD   = 8'hC4;
  localparam logic [7:0] OP_TERM     = 8'hC5;
  localparam logic [7:0] OP_REPEAT   = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR  = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD  = 8'hC8;
  localparam logic [7:0] OP_SGL_WR   = 8'hC9;
  localparam logic [7:0] OP_SGL_RD   = 8'hCA;
  localparam logic [7:0] OP_RESET    = 8'hCF;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_ECHO   = 2'd1,
    RES_STATUS = 2'd2
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_CRC, ST_RSP, ST_DONE
  } state_e;
endpackage

// File: rtl/spi_cmd_layout.sv
module spi_cmd_layout
  import spi_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0]                 opcode_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [LEN_W-1:0]                  len_i,
  input  logic [WORD_W-1:0]                 data_i,
  input  logic                              clockless_i,
  output logic [MAX_BYTES-1:0][BYTE_W-1:0]  frame_o,
  output logic [CNT_W-1:0]                  nbytes_o,
  output logic                              skip_o,
  output logic                              checked_o
);
  logic [BYTE_W-1:0] int_hi;

  assign int_hi = {addr_i[15] | clockless_i, addr_i[14:8]};

  always_comb begin
    frame_o    = '0;
    frame_o[0] = opcode_i;
    nbytes_o   = CNT_W'(4);
    skip_o     = 1'b0;
    checked_o  = 1'b1;
    case (opcode_i)
      OP_DMA_WR, OP_DMA_RD: begin
        frame_o[1] = addr_i[23:16];
        frame_o[2] = addr_i[15:8];
        frame_o[3] = addr_i[7:0];
        frame_o[4] = len_i[15:8];
        frame_o[5] = len_i[7:0];
        nbytes_o   = CNT_W'(6);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        frame_o[1] = addr_i[23:16];
        frame_o[2] = addr_i[15:8];
        frame_o[3] = addr_i[7:0];
        frame_o[4] = len_i[23:16];
        frame_o[5] = len_i[15:8];
        frame_o[6] = len_i[7:0];
        nbytes_o   = CNT_W'(7);
      end
      OP_INT_WR: begin
        frame_o[1] = int_hi;
        frame_o[2] = addr_i[7:0];
        frame_o[3] = data_i[31:24];
        frame_o[4] = data_i[23:16];
        frame_o[5] = data_i[15:8];
        frame_o[6] = data_i[7:0];
        nbytes_o   = CNT_W'(7);
        checked_o  = !clockless_i;
      end
      OP_INT_RD: begin
        frame_o[1] = int_hi;
        frame_o[2] = addr_i[7:0];
        checked_o  = !clockless_i;
      end
      OP_SGL_WR: begin
        frame_o[1] = addr_i[23:16];
        frame_o[2] = addr_i[15:8];
        frame_o[3] = addr_i[7:0];
        frame_o[4] = data_i[31:24];
        frame_o[5] = data_i[23:16];
        frame_o[6] = data_i[15:8];
        frame_o[7] = data_i[7:0];
        nbytes_o   = CNT_W'(8);
        checked_o  = !clockless_i;
      end
      OP_TERM, OP_REPEAT: begin
        skip_o = 1'b1;
      end
      OP_RESET: begin
        frame_o[1] = 8'hFF;
        frame_o[2] = 8'hFF;
        frame_o[3] = 8'hFF;
        skip_o     = 1'b1;
      end
      default: begin
        frame_o[1] = addr_i[23:16];
        frame_o[2] = addr_i[15:8];
        frame_o[3] = addr_i[7:0];
        checked_o  = !(clockless_i && opcode_i == OP_SGL_RD);
      end
    endcase
  end
endmodule

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d, step;

  always_comb begin
    step = crc_q;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      if (step[CRC_W-1] ^ byte_i[b])
        step = {step[CRC_W-2:0], 1'b0} ^ 7'h09;
      else
        step = {step[CRC_W-2:0], 1'b0};
    end
    crc_d = crc_q;
    if (clr_i)     crc_d = '1;
    else if (en_i) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  opcode_i,
  input  logic [23:0] addr_i,
  input  logic [23:0] len_i,
  input  logic [31:0] data_i,
  input  logic        crc_en_i,
  input  logic        clockless_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic [7:0]  rx_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  result_o
);
  state_e state_q, state_d;

  logic [BYTE_W-1:0] op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] data_q;
  logic              crc_en_q, clk_less_q;
  logic              load;

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        rcnt_q, rcnt_d;
  logic              echo_bad_q, echo_bad_d, stat_bad_q, stat_bad_d;

  logic [MAX_BYTES-1:0][BYTE_W-1:0] frame;
  logic [CNT_W-1:0]  nbytes;
  logic              skip, checked;
  logic [CRC_W-1:0]  crc;
  logic              hs, last_cmd, last_rsp;
  logic [1:0]        echo_pos;

  spi_cmd_layout u_layout (
    .opcode_i   (op_q),
    .addr_i     (addr_q),
    .len_i      (len_q),
    .data_i     (data_q),
    .clockless_i(clk_less_q),
    .frame_o    (frame),
    .nbytes_o   (nbytes),
    .skip_o     (skip),
    .checked_o  (checked)
  );

  spi_cmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (load),
    .en_i  (hs && state_q == ST_CMD),
    .byte_i(tx_data_o),
    .crc_o (crc)
  );

  assign load       = start_i && state_q == ST_IDLE;
  assign tx_valid_o = state_q == ST_CMD || state_q == ST_CRC || state_q == ST_RSP;
  assign hs         = tx_valid_o && tx_ready_i;
  assign last_cmd   = {1'b0, idx_q} == nbytes - CNT_W'(1);
  assign echo_pos   = {1'b0, skip};
  assign last_rsp   = rcnt_q == echo_pos + 2'd1;
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_DONE;

  always_comb begin
    case (state_q)
      ST_CMD:  tx_data_o = frame[idx_q];
      ST_CRC:  tx_data_o = {crc, 1'b0};
      default: tx_data_o = '0;
    endcase
  end

  always_comb begin
    result_o = RES_OK;
    if (done_o && checked) begin
      if (echo_bad_q)      result_o = RES_ECHO;
      else if (stat_bad_q) result_o = RES_STATUS;
    end
  end

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    rcnt_d     = rcnt_q;
    echo_bad_d = echo_bad_q;
    stat_bad_d = stat_bad_q;
    case (state_q)
      ST_IDLE: if (load) begin
        state_d    = ST_CMD;
        idx_d      = '0;
        rcnt_d     = '0;
        echo_bad_d = 1'b0;
        stat_bad_d = 1'b0;
      end
      ST_CMD: if (hs) begin
        idx_d = idx_q + IDX_W'(1);
        if (last_cmd) state_d = crc_en_q ? ST_CRC : ST_RSP;
      end
      ST_CRC: if (hs) state_d = ST_RSP;
      ST_RSP: if (hs) begin
        rcnt_d = rcnt_q + 2'd1;
        if (rcnt_q == echo_pos)        echo_bad_d = rx_data_i != op_q;
        if (rcnt_q == echo_pos + 2'd1) stat_bad_d = rx_data_i != 8'h00;
        if (last_rsp) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      rcnt_q     <= '0;
      echo_bad_q <= 1'b0;
      stat_bad_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      rcnt_q     <= rcnt_d;
      echo_bad_q <= echo_bad_d;
      stat_bad_q <= stat_bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      data_q     <= '0;
      crc_en_q   <= 1'b0;
      clk_less_q <= 1'b0;
    end else if (load) begin
      op_q       <= opcode_i;
      addr_q     <= addr_i;
      len_q      <= len_i;
      data_q     <= data_i;
      crc_en_q   <= crc_en_i;
      clk_less_q <= clockless_i;
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> result_o != 2'd3);

  // R6
  crc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC) |-> !tx_data_o[0]);

  // R7
  rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RSP) |-> tx_data_o == 8'h00);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tx_valid_o && !done_o));
endmodule

// File: tb/sim_spi_cmd_framer.sv
module sim_spi_cmd_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opcode_i;
  logic [23:0] addr_i;
  logic [23:0] len_i;
  logic [31:0] data_i;
  logic        crc_en_i, clockless_i;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i;
  logic [7:0]  rx_data_i;
  logic        busy_o, done_o;
  logic [1:0]  result_o;

  always #10 clk = ~clk;

  spi_cmd_framer u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit active = 0;
  bit [7:0] exp_q[$];
  bit [7:0] rx_q[$];
  int pos = 0;
  int exp_res = 0;
  int done_seen = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic bit [6:0] crc7(input bit [7:0] q[$]);
    int c = 127;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        int top = (c >> 6) & 1;
        c = (c << 1) & 127;
        if (top != int'(q[i][b])) c = c ^ 9;
      end
    end
    return 7'(c);
  endfunction

  // Monitor and stimulus for the byte stream, on the falling edge
  always @(negedge clk) begin
    if (rst_n && active) begin
      if (tx_valid_o) begin
        if (pos < exp_q.size())
          chk(tx_data_o == exp_q[pos], cur_tag, tx_data_o, exp_q[pos]);
        else
          chk(1'b0, "R7", tx_data_o, 0);
      end
      if (done_o) begin
        done_seen++;
        chk(pos == exp_q.size(), "R8", pos, exp_q.size());
        chk(result_o == 2'(exp_res), exp_res == 0 ? "R9" : "R8", result_o, exp_res);
      end
    end
    tx_ready_i = ($urandom % 4) != 0;
    rx_data_i  = (pos < rx_q.size()) ? rx_q[pos] : 8'h00;
    if (active && tx_valid_o && tx_ready_i) pos++;
  end

  task automatic run(input bit [7:0] op, input bit [23:0] a, input bit [23:0] l,
                     input bit [31:0] d, input bit crc, input bit cl,
                     input bit [7:0] echo, input bit [7:0] stat,
                     input string tag, input bit poke);
    bit [7:0] cmd[$];
    bit [7:0] hi;
    bit skip, chkd;
    cmd = {};
    hi = a[15:8] | (cl ? 8'h80 : 8'h00);
    skip = 0;
    chkd = 1;
    cmd.push_back(op);
    case (op)
      8'hC1, 8'hC2: cmd = {cmd, a[23:16], a[15:8], a[7:0], l[15:8], l[7:0]};
      8'hC7, 8'hC8: cmd = {cmd, a[23:16], a[15:8], a[7:0], l[23:16], l[15:8], l[7:0]};
      8'hC3: begin cmd = {cmd, hi, a[7:0], d[31:24], d[23:16], d[15:8], d[7:0]}; chkd = !cl; end
      8'hC4: begin cmd = {cmd, hi, a[7:0], 8'h00}; chkd = !cl; end
      8'hC9: begin cmd = {cmd, a[23:16], a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0]}; chkd = !cl; end
      8'hCA: begin cmd = {cmd, a[23:16], a[15:8], a[7:0]}; chkd = !cl; end
      8'hC5, 8'hC6: begin cmd = {cmd, 8'h00, 8'h00, 8'h00}; skip = 1; end
      8'hCF: begin cmd = {cmd, 8'hFF, 8'hFF, 8'hFF}; skip = 1; end
      default: cmd = {cmd, a[23:16], a[15:8], a[7:0]};
    endcase
    @(negedge clk);
    exp_q = cmd;
    if (crc) exp_q.push_back({crc7(cmd), 1'b0});
    rx_q = {};
    foreach (exp_q[i]) rx_q.push_back(8'hA5);
    if (skip) begin exp_q.push_back(8'h00); rx_q.push_back(8'h3C); end
    exp_q.push_back(8'h00); rx_q.push_back(echo);
    exp_q.push_back(8'h00); rx_q.push_back(stat);
    if (!chkd) exp_res = 0;
    else if (echo != op) exp_res = 1;
    else if (stat != 0) exp_res = 2;
    else exp_res = 0;
    pos = 0;
    done_seen = 0;
    cur_tag = tag;
    active = 1;
    opcode_i = op; addr_i = a; len_i = l; data_i = d;
    crc_en_i = crc; clockless_i = cl;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R11: start with a different command while busy
      opcode_i = 8'hCA; addr_i = 24'h0; crc_en_i = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_seen == 0) @(negedge clk);
    @(negedge clk);
    chk(done_seen == 1, "R8", done_seen, 1);
    chk(!busy_o && !done_o, "R11", busy_o, 0);
    active = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 0; opcode_i = 0; addr_i = 0; len_i = 0; data_i = 0;
    crc_en_i = 0; clockless_i = 0; tx_ready_i = 0; rx_data_i = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!tx_valid_o && !busy_o && !done_o, "R1", {tx_valid_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid_o && !busy_o && !done_o, "R1", {tx_valid_o, busy_o, done_o}, 0);

    run(8'hCA, 24'h123456, 24'h0, 32'h0, 0, 0, 8'hCA, 8'h00, "R2", 0);
    run(8'hC9, 24'hABCDEF, 24'h0, 32'hDEADBEEF, 1, 0, 8'hC9, 8'h00, "R4", 0);
    run(8'hC1, 24'h000100, 24'h000800, 32'h0, 1, 0, 8'hC1, 8'h00, "R2", 0);
    run(8'hC8, 24'h7F0001, 24'h012345, 32'h0, 0, 0, 8'hC8, 8'h00, "R2", 0);
    run(8'hC3, 24'h0000A4, 24'h0, 32'h01020304, 0, 1, 8'h00, 8'h07, "R3", 0);
    run(8'hC4, 24'h001234, 24'h0, 32'h0, 1, 0, 8'hC3, 8'h00, "R3", 0);
    run(8'hC2, 24'h040000, 24'h00FF, 32'h0, 0, 1, 8'hC2, 8'h05, "R9", 0);
    run(8'hCF, 24'h0, 24'h0, 32'h0, 1, 0, 8'hCF, 8'h00, "R5", 0);
    run(8'hC5, 24'h0, 24'h0, 32'h0, 0, 0, 8'h00, 8'h00, "R5", 0);
    run(8'hC6, 24'h0, 24'h0, 32'h0, 1, 0, 8'hC5, 8'h01, "R7", 0);
    run(8'hC4, 24'h00FF10, 24'h0, 32'h0, 1, 1, 8'hC4, 8'h22, "R6", 0);
    run(8'hC7, 24'h135790, 24'hFEDCBA, 32'h0, 1, 0, 8'hC7, 8'h00, "R10", 1);
    run(8'hCA, 24'h000010, 24'h0, 32'h0, 1, 0, 8'hCA, 8'h80, "R8", 0);
    run(8'hC9, 24'h00FFFF, 24'h0, 32'h11223344, 0, 1, 8'h55, 8'h66, "R9", 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule